// File: doc/BRIEF.md
# Carry-Select Completion Time Estimator

This block takes the propagate vector of an N-bit addition (the bitwise XOR of the two operands) and returns the nominal time, counted in unit gate delays, that a fixed-block carry-select adder with M-bit blocks needs to finish that addition. It is intended for performance models and hardware statistics gathering. A host streams propagate vectors in one at a time and collects the delay figures, for example to build an average-time histogram elsewhere.

The propagate vector is split into H = N/M blocks. Block 1 holds bits M-1..0 and block H holds the most significant bits. For each block the estimator derives:

- the carry setup configuration;
- the longest internal run of propagating bits;
- the block-sum setup time;
- the carry-selection setup time;
- the length of the unresolved chain that the block leads.

It folds these into one figure. The blocks are walked one per clock, from block H down to block 1, by a small state machine. A single capture register holds the vector during the walk.

Top module: `csel_time_est`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `ready_o` is 0 and `delay_o` is 0.
- R2: The reported delay is 2 + max(largest block-sum setup, largest carry term). The carry term of a block is its chain length plus its setup. For an all-zero vector the result is 4.
- R3: The carry configuration of a block is 1 plus the number of consecutive 1 bits counted downward from the block's top bit. A block whose bits are all 1 (configuration M+1) is unresolved. Every other block leads a chain.
- R4: The block-sum setup of a block is 2 plus the length of its longest run of consecutive 1 bits. A block with no 1 bits has setup 2.
- R5: Block 1 always leads a chain, because its carry-in is known. A leading block's chain length is the number of consecutive unresolved blocks directly above it. An unresolved block above block 1 contributes a carry term of 0.
- R6: The top block H, when leading, has setup equal to its configuration plus 1. When it is unresolved, its setup is 0.
- R7: An interior leading block has setup M when its configuration is below M and the block above it is unresolved. Otherwise its setup is its configuration plus 1. Block 1 has setup M when it is unresolved, or when its configuration is below M and block 2 is unresolved. Otherwise its setup equals its configuration.
- R8: A `valid_i` accepted at a clock edge makes `ready_o` high for exactly one cycle, H+1 edges later. `delay_o` carries the result in that cycle.
- R9: A `valid_i` that arrives while a computation is in progress is ignored. It does not change the pending result or start another one.
- R10: `delay_o` keeps its value until the next result is delivered. Every delivered value lies between 4 and M+H+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Start strobe; `prop_i` is captured when the block is idle |
| prop_i | input | N | Propagate vector of the addition to be timed |
| ready_o | output | 1 | One-cycle pulse marking a new result |
| delay_o | output | TW | Completion time in unit gate delays, TW = clog2(M+H+5)+1 |

## Verification
The bench builds three copies of the block side by side.

- The 8-bit copy with 2-bit blocks (four blocks) covers first, interior and top blocks in every combination of leading and unresolved.
- The 6-bit copy with 3-bit blocks brings in configurations below M and internal runs that do not touch the block edges.
- The 5-bit copy with 1-bit blocks covers the ripple-adder limit.

All three are swept over every possible propagate vector and compared against an arithmetic model in the bench. Directed cases cover all-zero and all-one vectors, a strobe arriving mid-walk, and hold of the output between results.

// File: rtl/csel_est_pkg.sv
package csel_est_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_st_e;

endpackage

// File: rtl/csel_blk_prof.sv
// Per-block profile: carry configuration, unresolved flag and longest
// internal run of propagating bits (R3, R4).
module csel_blk_prof #(
  parameter int M  = 2,
  parameter int SW = 2
) (
  input  logic [M-1:0]  blk_i,
  output logic [SW-1:0] sigma_o,
  output logic [SW-1:0] run_max_o,
  output logic          unres_o
);

  logic [SW-1:0] sig_acc;
  logic          halted;
  logic [SW-1:0] cur_run;
  logic [SW-1:0] best_run;

  always_comb begin
    sig_acc = SW'(1);
    halted  = 1'b0;
    for (int i = M - 1; i >= 0; i--) begin
      if (!halted) begin
        if (blk_i[i]) sig_acc = sig_acc + SW'(1);
        else          halted  = 1'b1;
      end
    end
  end

  always_comb begin
    cur_run  = '0;
    best_run = '0;
    for (int i = 0; i < M; i++) begin
      if (blk_i[i]) cur_run = cur_run + SW'(1);
      else          cur_run = '0;
      if (cur_run > best_run) best_run = cur_run;
    end
  end

  assign sigma_o   = sig_acc;
  assign run_max_o = best_run;
  assign unres_o   = (sig_acc == SW'(M + 1));

endmodule

// File: rtl/csel_setup_rule.sv
// Carry-selection setup of one block from its position and neighbour (R6, R7).
module csel_setup_rule #(
  parameter int M  = 2,
  parameter int SW = 2,
  parameter int TW = 5
) (
  input  logic [SW-1:0] sigma_i,
  input  logic          unres_i,
  input  logic          next_unres_i,
  input  logic          is_first_i,
  input  logic          is_last_i,
  output logic [TW-1:0] setup_o
);

  logic          short_lead;
  logic [TW-1:0] sig_w;

  assign sig_w      = TW'(sigma_i);
  assign short_lead = (sigma_i < SW'(M)) && next_unres_i;

  always_comb begin
    if (is_first_i) begin
      setup_o = (short_lead || unres_i) ? TW'(M) : sig_w;
    end else if (unres_i) begin
      setup_o = '0;
    end else if (is_last_i) begin
      setup_o = sig_w + TW'(1);
    end else begin
      setup_o = short_lead ? TW'(M) : (sig_w + TW'(1));
    end
  end

endmodule

// File: rtl/csel_scan_core.sv
// Walks the blocks from the top one down to block 1, one per clock, and
// accumulates the two maxima that form the result (R2, R5, R8, R9, R10).
module csel_scan_core
  import csel_est_pkg::*;
#(
  parameter int N  = 16,
  parameter int M  = 2,
  parameter int SW = 2,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [N-1:0]  prop_i,
  output logic [M-1:0]  blk_o,
  output logic          is_first_o,
  output logic          is_last_o,
  output logic          next_unres_o,
  input  logic          unres_i,
  input  logic [SW-1:0] run_max_i,
  input  logic [TW-1:0] setup_i,
  output logic          ready_o,
  output logic [TW-1:0] delay_o
);

  localparam int H  = N / M;
  localparam int HW = $clog2(H + 1);

  scan_st_e      state_q;
  logic [N-1:0]  preg_q;
  logic [HW-1:0] idx_q;
  logic [TW-1:0] chain_q;
  logic [TW-1:0] max_a_q;
  logic [TW-1:0] max_cs_q;

  logic [TW-1:0] a_term;
  logic [TW-1:0] cs_term;
  logic          upper_unres;

  assign blk_o        = preg_q[N-1 -: M];
  assign is_first_o   = (idx_q == HW'(1));
  assign is_last_o    = (idx_q == HW'(H));
  assign next_unres_o = (chain_q != '0);

  assign upper_unres = unres_i && !is_first_o;
  assign a_term      = TW'(run_max_i) + TW'(2);
  assign cs_term     = upper_unres ? '0 : (chain_q + setup_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      preg_q   <= '0;
      idx_q    <= '0;
      chain_q  <= '0;
      max_a_q  <= '0;
      max_cs_q <= '0;
      ready_o  <= 1'b0;
      delay_o  <= '0;
    end else begin
      ready_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (valid_i) begin
            preg_q   <= prop_i;
            idx_q    <= HW'(H);
            chain_q  <= '0;
            max_a_q  <= '0;
            max_cs_q <= '0;
            state_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (a_term > max_a_q)   max_a_q  <= a_term;
          if (cs_term > max_cs_q) max_cs_q <= cs_term;
          chain_q <= upper_unres ? (chain_q + TW'(1)) : '0;
          preg_q  <= preg_q << M;
          idx_q   <= idx_q - HW'(1);
          if (is_first_o) state_q <= ST_FIN;
        end
        ST_FIN: begin
          delay_o <= TW'(2) + ((max_a_q > max_cs_q) ? max_a_q : max_cs_q);
          ready_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/csel_time_est.sv
module csel_time_est #(
  parameter  int N  = 16,
  parameter  int M  = 2,
  localparam int H  = N / M,
  localparam int SW = $clog2(M + 2),
  localparam int TW = $clog2(M + H + 5) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [N-1:0]  prop_i,
  output logic          ready_o,
  output logic [TW-1:0] delay_o
);

  logic [M-1:0]  blk;
  logic          is_first;
  logic          is_last;
  logic          next_unres;
  logic [SW-1:0] sigma;
  logic [SW-1:0] run_max;
  logic          unres;
  logic [TW-1:0] setup;

  csel_blk_prof #(.M(M), .SW(SW)) u_prof (
    .blk_i     (blk),
    .sigma_o   (sigma),
    .run_max_o (run_max),
    .unres_o   (unres)
  );

  csel_setup_rule #(.M(M), .SW(SW), .TW(TW)) u_setup (
    .sigma_i      (sigma),
    .unres_i      (unres),
    .next_unres_i (next_unres),
    .is_first_i   (is_first),
    .is_last_i    (is_last),
    .setup_o      (setup)
  );

  csel_scan_core #(.N(N), .M(M), .SW(SW), .TW(TW)) u_core (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (valid_i),
    .prop_i       (prop_i),
    .blk_o        (blk),
    .is_first_o   (is_first),
    .is_last_o    (is_last),
    .next_unres_o (next_unres),
    .unres_i      (unres),
    .run_max_i    (run_max),
    .setup_i      (setup),
    .ready_o      (ready_o),
    .delay_o      (delay_o)
  );

endmodule

// File: rtl/csel_time_est_chk.sv
module csel_time_est_chk #(
  parameter int M  = 2,
  parameter int H  = 8,
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic          ready_o,
  input logic [TW-1:0] delay_o
);

  logic          busy_q;
  logic [TW-1:0] age_q;
  logic          accept;

  assign accept = valid_i && (!busy_q || ready_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      age_q  <= '0;
    end else if (ready_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      age_q <= age_q + TW'(1);
    end
  end

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R8
  ready_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (busy_q && age_q == TW'(H + 1)));

  // R10
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> $stable(delay_o));

  // R10
  delay_range_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (delay_o >= TW'(4) && delay_o <= TW'(M + H + 4)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ready_o && delay_o == '0));

endmodule

bind csel_time_est csel_time_est_chk #(.M(M), .H(H), .TW(TW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .delay_o (delay_o)
);

// File: tb/csel_time_est_bench.sv
module csel_time_est_bench;

  localparam int NA = 8, MA = 2, HA = NA / MA, TWA = $clog2(MA + HA + 5) + 1;
  localparam int NB = 6, MB = 3, HB = NB / MB, TWB = $clog2(MB + HB + 5) + 1;
  localparam int NC = 5, MC = 1, HC = NC / MC, TWC = $clog2(MC + HC + 5) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           va, vb, vc;
  logic [NA-1:0]  pa;
  logic [NB-1:0]  pb;
  logic [NC-1:0]  pc;
  logic           ra, rb, rc;
  logic [TWA-1:0] da;
  logic [TWB-1:0] db;
  logic [TWC-1:0] dc;

  csel_time_est #(.N(NA), .M(MA)) u_csel_time_est (
    .clk(clk), .rst(rst), .valid_i(va), .prop_i(pa), .ready_o(ra), .delay_o(da));
  csel_time_est #(.N(NB), .M(MB)) u_csel_time_est_b (
    .clk(clk), .rst(rst), .valid_i(vb), .prop_i(pb), .ready_o(rb), .delay_o(db));
  csel_time_est #(.N(NC), .M(MC)) u_csel_time_est_c (
    .clk(clk), .rst(rst), .valid_i(vc), .prop_i(pc), .ready_o(rc), .delay_o(dc));

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Arithmetic model of the completion time
  function automatic int model(input int unsigned p, input int n, input int m);
    int h = n / m;
    int sig[32];
    int best;
    best = 0;
    for (int c = 0; c < h; c++) begin
      int s = 1;
      int run = 0;
      int lng = 0;
      bit go = 1;
      for (int j = m - 1; j >= 0; j--) begin
        if (go && p[c*m + j]) s++;
        else go = 0;
      end
      sig[c] = s;
      for (int j = 0; j < m; j++) begin
        run = p[c*m + j] ? run + 1 : 0;
        if (run > lng) lng = run;
      end
      if (lng + 2 > best) best = lng + 2;
    end
    for (int c = 0; c < h; c++) begin
      bit un = (sig[c] == m + 1);
      bit nx = (c + 1 < h) ? (sig[c+1] == m + 1) : 1'b0;
      int len = 0;
      int st;
      if (c > 0 && un) continue;
      for (int d = c + 1; d < h; d++) begin
        if (sig[d] != m + 1) break;
        len++;
      end
      if (c == 0)          st = ((sig[c] < m && nx) || un) ? m : sig[c];
      else if (c == h - 1) st = sig[c] + 1;
      else                 st = (sig[c] < m && nx) ? m : sig[c] + 1;
      if (len + st > best) best = len + st;
    end
    return 2 + best;
  endfunction

  int res_a, res_b, res_c, lat_a, lat_b, lat_c, cnt_a, cnt_b, cnt_c;

  // Start all three copies with slices of v, collect pulses for 20 cycles.
  // If extra is set, a second strobe with ~v is applied one cycle later.
  task automatic run3(input logic [7:0] v, input bit extra);
    cnt_a = 0; cnt_b = 0; cnt_c = 0;
    lat_a = -1; lat_b = -1; lat_c = -1;
    @(negedge clk);
    va = 1; vb = 1; vc = 1;
    pa = v; pb = v[NB-1:0]; pc = v[NC-1:0];
    @(negedge clk);
    if (extra) begin
      pa = ~v; pb = ~v[NB-1:0]; pc = ~v[NC-1:0];
    end else begin
      va = 0; vb = 0; vc = 0;
    end
    for (int cyc = 1; cyc <= 20; cyc++) begin
      @(negedge clk);
      va = 0; vb = 0; vc = 0;
      if (ra) begin cnt_a++; res_a = int'(da); if (lat_a < 0) lat_a = cyc; end
      if (rb) begin cnt_b++; res_b = int'(db); if (lat_b < 0) lat_b = cyc; end
      if (rc) begin cnt_c++; res_c = int'(dc); if (lat_c < 0) lat_c = cyc; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    va = 0; vb = 0; vc = 0; pa = '0; pb = '0; pc = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk(!ra && !rb && !rc, "R1 ready in reset", int'(ra), 0);
    chk(da == '0 && db == '0 && dc == '0, "R1 delay in reset", int'(da), 0);
    rst = 0;
    @(negedge clk);
    chk(!ra && da == '0, "R1 after release", int'(da), 0);

    // R2 all-zero vector: every copy reports 4
    run3(8'h00, 0);
    chk(res_a == 4, "R2 zeros M=2", res_a, 4);
    chk(res_b == 4, "R2 zeros M=3", res_b, 4);
    chk(res_c == 4, "R2 zeros M=1", res_c, 4);

    // R5 all-one vector: block 1 leads a chain through every block above
    run3(8'hFF, 0);
    chk(res_a == 7, "R5 ones M=2", res_a, 7);
    chk(res_b == 7, "R5 ones M=3", res_b, 7);
    chk(res_c == 7, "R5 ones M=1 ripple", res_c, 7);

    // R4 block 1 fully propagating, rest killing
    run3(8'h03, 0);
    chk(res_a == 6, "R4 low block run", res_a, 6);

    // R6 top block unresolved
    run3(8'hC0, 0);
    chk(res_a == model(32'hC0, NA, MA), "R6 top unresolved", res_a, model(32'hC0, NA, MA));

    // R7 short leading block below an unresolved one
    run3(8'h30, 0);
    chk(res_a == model(32'h30, NA, MA), "R7 interior short lead", res_a, model(32'h30, NA, MA));

    // R8 latency and pulse width
    run3(8'h5A, 0);
    chk(lat_a == HA + 1, "R8 latency M=2", lat_a, HA + 1);
    chk(lat_b == HB + 1, "R8 latency M=3", lat_b, HB + 1);
    chk(lat_c == HC + 1, "R8 latency M=1", lat_c, HC + 1);
    chk(cnt_a == 1 && cnt_b == 1 && cnt_c == 1, "R8 single pulse", cnt_a, 1);

    // R9 strobe during a walk is ignored
    run3(8'hFF, 1);
    chk(res_a == 7 && cnt_a == 1, "R9 busy strobe M=2", res_a, 7);
    chk(res_c == 7 && cnt_c == 1, "R9 busy strobe M=1", res_c, 7);

    // R10 result held between deliveries
    repeat (6) @(negedge clk);
    chk(int'(da) == res_a && !ra, "R10 hold", int'(da), res_a);

    // R2 R3 R4 R5 R6 R7: exhaustive sweep of all three copies
    for (int v = 0; v < 256; v++) begin
      int ea, eb, ec;
      run3(8'(v), 0);
      ea = model(v, NA, MA);
      eb = model(v & 32'h3F, NB, MB);
      ec = model(v & 32'h1F, NC, MC);
      chk(res_a == ea && cnt_a == 1, "R2 sweep M=2", res_a, ea);
      if (v < 64) chk(res_b == eb && cnt_b == 1, "R3 sweep M=3", res_b, eb);
      if (v < 32) chk(res_c == ec && cnt_c == 1, "R5 sweep M=1", res_c, ec);
    end

    finish_run();
  end

endmodule